// File: doc/BRIEF.md
# Burst Next-Address Sequencer

This block sits on the slave side of a registered-feedback Wishbone port. It watches every strobed, acknowledged beat and works out the word address of the beat that should follow. A memory behind the slave can then start fetching that word before the master presents it. The block reads the 3-bit cycle-type tag and the 2-bit burst-type tag on the beat. It turns them into one of four outcomes: a repeat of the same address, a linear step, a wrapping step in an aligned window of 4, 8 or 16 words, or no prediction.

The address input is a word address, so the byte-lane bits are already removed. A valid flag says when the predicted address may be used. A separate burst indication shows, in the same cycle, that the beat now on the bus is tagged as part of a burst. In the wrap modes only the low address bits move, and the bits above the wrap window are kept as they are.

Top module: `wbseq_top`

## Requirements
- R1: After reset, `next_adr_o` is 0 and `next_vld_o` is 0.
- R2: The prediction changes only after a rising clock edge at which `cyc_i`, `stb_i` and `ack_i` are all 1 (an acknowledged beat). While `cyc_i` stays 1 and no beat occurs, `next_adr_o` and `next_vld_o` hold their values.
- R3: An acknowledged beat with cycle type 1 (constant-address burst) makes `next_adr_o` equal to that beat's `adr_i` and sets `next_vld_o` to 1. Both are visible from the clock edge that takes the beat.
- R4: An acknowledged beat with cycle type 2 and burst type 0 (linear) predicts `adr_i + 1`, modulo 2^AW, and sets `next_vld_o` to 1.
- R5: An acknowledged beat with cycle type 2 and burst type 1, 2 or 3 (wrap-4, wrap-8, wrap-16) predicts an address in which the low 2, 3 or 4 bits are incremented modulo 4, 8 or 16. All higher bits equal those of `adr_i`, and `next_vld_o` is set to 1.
- R6: The burst type has no effect when the cycle type is 1. A constant-address beat predicts its own address for every burst type.
- R7: An acknowledged beat with cycle type 7 (final beat) clears `next_vld_o` and leaves `next_adr_o` unchanged.
- R8: An acknowledged beat with cycle type 0 (classic) or a reserved cycle type (3 to 6) clears `next_vld_o` and leaves `next_adr_o` unchanged.
- R9: At a clock edge where `cyc_i` is 0, `next_vld_o` is cleared, whatever the other inputs are.
- R10: `burst_o` is combinational. It is 1 exactly when `cyc_i` and `stb_i` are 1 and `cti_i` is 1, 2 or 7.
- R11: While `next_vld_o` is 1, an acknowledged beat whose `we_i` differs from that of the previous acknowledged beat clears `next_vld_o` and leaves `next_adr_o` unchanged. The beat after it predicts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Beat strobe |
| we_i | input | 1 | Direction of the beat, 1 = write |
| adr_i | input | AW | Word address of the current beat |
| cti_i | input | 3 | Cycle-type tag: 0 classic, 1 constant, 2 incrementing, 7 final, others reserved |
| bte_i | input | 2 | Burst-type tag: 0 linear, 1 wrap-4, 2 wrap-8, 3 wrap-16 |
| ack_i | input | 1 | Slave acknowledge of the current beat |
| next_adr_o | output | AW | Predicted word address of the following beat |
| next_vld_o | output | 1 | Prediction may be used |
| burst_o | output | 1 | Current strobed beat carries a burst cycle type |

## Verification
The tests are built to separate the ways the address step could be computed wrongly.

- **Constant bursts** are run with burst type 3 applied. This separates "repeat the address" from any wrap step.
- **Linear bursts** start two words below the top of the address space. This shows a full-width carry that wraps round to zero.
- **Wrap-8 bursts** start at offset 6 with non-zero upper bits. Wrap-4 and wrap-16 bursts start just below their window edge. These show whether only the low bits roll over while the upper bits stay put.
- **Termination and hold cases** are also run:
  - Stalled beats without an acknowledge.
  - Final, classic and reserved beats.
  - A drop of the bus cycle in the middle of a burst.
  - A change of direction within a burst.

  Each of these tells a hold of the prediction apart from a clear of the valid flag.

// File: rtl/wbseq_pkg.sv
package wbseq_pkg;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_CONST = 2'd1,
    K_INCR  = 2'd2,
    K_LAST  = 2'd3
  } beat_kind_e;

  localparam logic [2:0] CTI_CLASSIC = 3'd0;
  localparam logic [2:0] CTI_CONST   = 3'd1;
  localparam logic [2:0] CTI_INCR    = 3'd2;
  localparam logic [2:0] CTI_END     = 3'd7;

  localparam logic [1:0] BTE_LINEAR = 2'd0;
  localparam logic [1:0] BTE_WRAP4  = 2'd1;
  localparam logic [1:0] BTE_WRAP8  = 2'd2;
  localparam logic [1:0] BTE_WRAP16 = 2'd3;

  localparam int NUM_WRAPS = 3;
  localparam int MIN_WRAP_BITS = 2;

  function automatic beat_kind_e classify(input logic [2:0] cti);
    beat_kind_e k;
    case (cti)
      CTI_CONST: k = K_CONST;
      CTI_INCR:  k = K_INCR;
      CTI_END:   k = K_LAST;
      default:   k = K_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/wbseq_decode.sv
module wbseq_decode
  import wbseq_pkg::*;
(
  input  logic       cyc_i,
  input  logic       stb_i,
  input  logic       ack_i,
  input  logic [2:0] cti_i,
  output beat_kind_e kind_o,
  output logic       beat_o,
  output logic       burst_o
);

  assign kind_o  = classify(cti_i);
  assign beat_o  = cyc_i & stb_i & ack_i;
  assign burst_o = cyc_i & stb_i & (kind_o != K_NONE);

  always_comb begin
    if (burst_o) begin
      AST_BURST_QUALIFIED: assert (cyc_i && stb_i && (cti_i == 3'd1 || cti_i == 3'd2 || cti_i == 3'd7)); // R10
    end
  end

endmodule

// File: rtl/wbseq_step.sv
module wbseq_step
  import wbseq_pkg::*;
#(
  parameter int AW = 30
) (
  input  logic [AW-1:0] adr_i,
  input  logic [1:0]    bte_i,
  input  beat_kind_e    kind_i,
  output logic [AW-1:0] nxt_o
);

  logic [AW-1:0] lin_nxt;
  logic [AW-1:0] wrap_nxt [NUM_WRAPS];

  assign lin_nxt = adr_i + AW'(1);

  for (genvar g = 0; g < NUM_WRAPS; g++) begin : g_wrap
    localparam int LB = MIN_WRAP_BITS + g;
    localparam logic [AW-1:0] LMASK = (AW'(1) << LB) - AW'(1);
    assign wrap_nxt[g] = (adr_i & ~LMASK) | (lin_nxt & LMASK);
  end

  always_comb begin
    nxt_o = adr_i;
    if (kind_i == K_INCR) begin
      case (bte_i)
        BTE_WRAP4:  nxt_o = wrap_nxt[0];
        BTE_WRAP8:  nxt_o = wrap_nxt[1];
        BTE_WRAP16: nxt_o = wrap_nxt[2];
        default:    nxt_o = lin_nxt;
      endcase
    end
  end

  always_comb begin
    if (kind_i == K_INCR && bte_i != BTE_LINEAR) begin
      AST_WRAP_KEEPS_UPPER: assert ((nxt_o >> (int'(bte_i) + 1)) == (adr_i >> (int'(bte_i) + 1))); // R5
    end
    if (kind_i == K_CONST) begin
      AST_CONST_NO_STEP: assert (nxt_o == adr_i); // R6
    end
  end

endmodule

// File: rtl/wbseq_track.sv
module wbseq_track
  import wbseq_pkg::*;
#(
  parameter int AW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_i,
  input  logic          we_i,
  input  logic          beat_i,
  input  beat_kind_e    kind_i,
  input  logic [AW-1:0] adr_i,
  input  logic [AW-1:0] step_i,
  output logic [AW-1:0] adr_q,
  output logic          vld_q
);

  logic dir_q;
  logic dir_break;
  logic predicts;

  assign dir_break = vld_q & (we_i != dir_q);
  assign predicts  = (kind_i == K_CONST) | (kind_i == K_INCR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q <= '0;
      vld_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (!cyc_i) begin
      vld_q <= 1'b0;
    end else if (beat_i) begin
      dir_q <= we_i;
      if (dir_break || !predicts) begin
        vld_q <= 1'b0;
      end else begin
        vld_q <= 1'b1;
        adr_q <= step_i;
      end
    end
  end

  AST_CONST_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && beat_i && kind_i == K_CONST && !dir_break) |=> (adr_q == $past(adr_i) && vld_q)); // R3
  AST_END_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && beat_i && kind_i == K_LAST) |=> (!vld_q && $stable(adr_q))); // R7
  AST_RSV_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && beat_i && kind_i == K_NONE) |=> (!vld_q && $stable(adr_q))); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && !beat_i) |=> ($stable(adr_q) && $stable(vld_q))); // R2
  AST_DIR_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && beat_i && dir_break) |=> (!vld_q && $stable(adr_q))); // R11

endmodule

// File: rtl/wbseq_top.sv
module wbseq_top
  import wbseq_pkg::*;
#(
  parameter int AW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_i,
  input  logic          stb_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  logic [2:0]    cti_i,
  input  logic [1:0]    bte_i,
  input  logic          ack_i,
  output logic [AW-1:0] next_adr_o,
  output logic          next_vld_o,
  output logic          burst_o
);

  beat_kind_e    kind;
  logic          beat;
  logic [AW-1:0] step_adr;

  wbseq_decode i_decode (
    .cyc_i   (cyc_i),
    .stb_i   (stb_i),
    .ack_i   (ack_i),
    .cti_i   (cti_i),
    .kind_o  (kind),
    .beat_o  (beat),
    .burst_o (burst_o)
  );

  wbseq_step #(.AW(AW)) i_step (
    .adr_i  (adr_i),
    .bte_i  (bte_i),
    .kind_i (kind),
    .nxt_o  (step_adr)
  );

  wbseq_track #(.AW(AW)) i_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .cyc_i  (cyc_i),
    .we_i   (we_i),
    .beat_i (beat),
    .kind_i (kind),
    .adr_i  (adr_i),
    .step_i (step_adr),
    .adr_q  (next_adr_o),
    .vld_q  (next_vld_o)
  );

  AST_CYC_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_i |=> !next_vld_o); // R9
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && cti_i == CTI_INCR && bte_i == BTE_LINEAR && !next_vld_o)
      |=> (next_adr_o == $past(adr_i) + AW'(1))); // R4

endmodule

// File: tb/test_wbseq_top.sv
module test_wbseq_top;

  localparam int AW = 30;

  typedef struct {
    logic [AW-1:0] adr;
    logic          vld;
    logic [23:0]   tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc_i = 1'b0;
  logic          stb_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] adr_i = '0;
  logic [2:0]    cti_i = 3'd0;
  logic [1:0]    bte_i = 2'd0;
  logic          ack_i = 1'b0;
  logic [AW-1:0] next_adr_o;
  logic          next_vld_o;
  logic          burst_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t sb [$];

  logic [AW-1:0] m_adr = '0;
  logic          m_vld = 1'b0;
  logic          m_dir = 1'b0;

  always #2 clk = ~clk;

  wbseq_top #(.AW(AW)) i_wbseq_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_i      (cyc_i),
    .stb_i      (stb_i),
    .we_i       (we_i),
    .adr_i      (adr_i),
    .cti_i      (cti_i),
    .bte_i      (bte_i),
    .ack_i      (ack_i),
    .next_adr_o (next_adr_o),
    .next_vld_o (next_vld_o),
    .burst_o    (burst_o)
  );

  function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] a, input logic [1:0] b);
    longint unsigned win, low, base;
    if (b == 2'd0) return a + 1'b1;
    win  = 64'd1 << (b + 1);
    low  = longint'(a) % win;
    base = longint'(a) - low;
    return AW'(base + ((low + 1) % win));
  endfunction

  task automatic drive(input logic c, input logic s, input logic k, input logic w,
                       input logic [AW-1:0] a, input logic [2:0] t, input logic [1:0] b,
                       input logic [23:0] tag);
    exp_t e;
    logic exp_b;
    @(negedge clk);
    cyc_i = c; stb_i = s; ack_i = k; we_i = w; adr_i = a; cti_i = t; bte_i = b;
    if (!c) begin
      m_vld = 1'b0;
    end else if (c && s && k) begin
      if (m_vld && (w != m_dir)) m_vld = 1'b0;
      else if (t == 3'd1) begin m_vld = 1'b1; m_adr = a; end
      else if (t == 3'd2) begin m_vld = 1'b1; m_adr = ref_next(a, b); end
      else m_vld = 1'b0;
      m_dir = w;
    end
    e.adr = m_adr; e.vld = m_vld; e.tag = tag;
    sb.push_back(e);
    #1;
    exp_b = c && s && (t == 3'd1 || t == 3'd2 || t == 3'd7);
    checks++;
    if (burst_o !== exp_b) begin
      fails++;
      $display("FAIL R10 burst_o actual=%0b expected=%0b", burst_o, exp_b);
    end
  endtask

  task automatic beat(input logic w, input logic [AW-1:0] a, input logic [2:0] t,
                      input logic [1:0] b, input logic [23:0] tag);
    drive(1'b1, 1'b1, 1'b1, w, a, t, b, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (next_adr_o !== e.adr || next_vld_o !== e.vld) begin
          fails++;
          $display("FAIL %s adr actual=%h expected=%h vld actual=%0b expected=%0b",
                   e.tag, next_adr_o, e.adr, next_vld_o, e.vld);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [AW-1:0] hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (next_adr_o !== '0 || next_vld_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset adr actual=%h expected=0 vld actual=%0b expected=0",
               next_adr_o, next_vld_o);
    end

    // R3 / R6: constant bursts, burst type 3 must not matter
    beat(1'b0, 30'h123, 3'd1, 2'd3, "R3");
    beat(1'b0, 30'h123, 3'd1, 2'd3, "R6");
    beat(1'b0, 30'h123, 3'd1, 2'd1, "R6");
    // R7: final beat clears valid, address holds
    beat(1'b0, 30'h123, 3'd7, 2'd0, "R7");
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 3'd0, 2'd0, "R9");

    // R4: linear across the top of the address space
    beat(1'b0, 30'h3FFF_FFFE, 3'd2, 2'd0, "R4");
    beat(1'b0, 30'h3FFF_FFFF, 3'd2, 2'd0, "R4");
    // R2: stall beats without acknowledge
    drive(1'b1, 1'b1, 1'b0, 1'b0, 30'h0, 3'd2, 2'd0, "R2");
    drive(1'b1, 1'b0, 1'b1, 1'b0, 30'h5, 3'd1, 2'd0, "R2");
    beat(1'b0, 30'h0, 3'd7, 2'd0, "R7");
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 3'd0, 2'd0, "R9");

    // R5: wrap-8 from offset 6, upper bits set
    hi = 30'h2AB_CD40;
    for (int i = 0; i < 8; i++) begin
      beat(1'b0, hi | AW'((6 + i) % 8), 3'd2, 2'd2, "R5");
    end
    beat(1'b0, hi | AW'(6), 3'd7, 2'd2, "R7");
    // R5: wrap-4 from offset 3, wrap-16 from offset 15
    beat(1'b1, 30'h155_5553, 3'd2, 2'd1, "R5");
    beat(1'b1, 30'h155_5550, 3'd2, 2'd1, "R5");
    beat(1'b1, 30'h0F0_F0FF, 3'd2, 2'd3, "R5");
    beat(1'b1, 30'h0F0_F0F0, 3'd2, 2'd3, "R5");

    // R8: classic and reserved types clear valid
    beat(1'b1, 30'h77, 3'd0, 2'd0, "R8");
    for (int t = 3; t <= 6; t++) begin
      beat(1'b1, 30'h80, 3'd2, 2'd0, "R4");
      beat(1'b1, 30'h99, 3'(t), 2'd0, "R8");
    end

    // R9: cycle drops mid-burst
    beat(1'b1, 30'h200, 3'd2, 2'd0, "R4");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 30'h201, 3'd2, 2'd0, "R9");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 30'h201, 3'd2, 2'd0, "R2");

    // R11: direction change inside a burst
    beat(1'b0, 30'h40, 3'd2, 2'd0, "R4");
    beat(1'b1, 30'h41, 3'd2, 2'd0, "R11");
    beat(1'b1, 30'h42, 3'd2, 2'd0, "R11");
    beat(1'b1, 30'h43, 3'd7, 2'd0, "R7");

    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 3'd0, 2'd0, "R9");
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 3'd0, 2'd0, "R9");
    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule